// File: doc/BRIEF.md
# Line-Splitting DMA Request Sequencer

This block takes a single DMA transfer (start byte address, byte count, direction) and turns it into a chain of memory requests, none of which crosses a cache-line boundary. Each request carries a line address, a byte offset inside that line, a byte count and a load/store flag. Only one request is ever in flight. The next one goes out only after the memory side has answered the previous one, with line data for a load or a bare acknowledgement for a store.

For loads, the useful bytes of each returned line are shifted down to byte 0. They are presented on a read-out port together with their position in the transfer, so a consumer can place them into a buffer. For stores, the block shows the transfer-relative index of the next byte it needs. The data source answers with one line's worth of bytes starting at that index, and the block moves them to the chunk's line offset. Every accepted transfer gets an 8-bit wrapping ID, visible at accept time and returned with the completion pulse.

Top module: `dma_line_seq`

## Requirements
- R1: While a transfer is active, `busy` is high and `req_ready` is low. `busy` rises on the cycle after a legal non-zero-length request is accepted and falls in the same cycle as the completion pulse.
- R2: `req_kind` encodes 1 = load and 2 = store. Codes 0 and 3..7 (null, instruction fetch, locked read, locked write, read-modify-write read and write) are illegal. Accepting an illegal code pulses `req_err` for one cycle on the next cycle, starts no transfer and consumes no ID.
- R3: The first chunk has offset = start address mod LINE_BYTES. Its length is the total length if offset + length <= LINE_BYTES, otherwise LINE_BYTES - offset.
- R4: Each later chunk addresses start + bytes completed, which lies on a line boundary, so its offset is 0. `chk_line_addr` is always the chunk address with the low log2(LINE_BYTES) bits cleared.
- R5: Each later chunk's length is min(total - bytes completed, LINE_BYTES).
- R6: At most one chunk is outstanding. `chk_valid` stays high with stable fields until `chk_ready`, stays low while a response is awaited, and the next chunk appears only after `rsp_valid`.
- R7: On the response that brings bytes completed up to the total length, `done_valid` pulses for one cycle on the next cycle with `done_id` equal to the transfer's ID.
- R8: For a load, `rd_valid` pulses one cycle after each response. `rd_pos` is the bytes completed before that chunk, `rd_len` is the chunk length, and `rd_bytes` byte j (bits 8j+7:8j) is returned line byte (chunk offset + j).
- R9: For a store, `wr_base` equals the bytes completed so far. `chk_data` byte (offset + i) equals `wr_bytes` byte i for every i below the chunk length, and `chk_store` is 1. For a load, `chk_store` is 0 and `chk_data` is zero.
- R10: `req_id` shows the ID the next legal request will receive. It is 0 after reset and advances by 1 (mod 256) on each legal accept.
- R11: A legal request of length 0 issues no chunk, leaves `busy` low, and pulses `done_valid` with its ID on the next cycle.
- R12: After reset `busy`, `chk_valid`, `rd_valid`, `done_valid` and `req_err` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Transfer request offered |
| req_ready | output | 1 | Request can be taken (idle) |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Transfer length in bytes |
| req_kind | input | 3 | Request type code (see R2) |
| req_id | output | ID_W | ID the next legal request receives |
| req_err | output | 1 | Illegal request type pulse |
| busy | output | 1 | Transfer in progress |
| wr_base | output | LEN_W | Transfer index of the first store byte wanted |
| wr_bytes | input | LINE_BYTES*8 | Store bytes from index wr_base, byte 0 first |
| chk_valid | output | 1 | Chunk request valid |
| chk_ready | input | 1 | Chunk request taken |
| chk_line_addr | output | ADDR_W | Line-aligned chunk address |
| chk_offset | output | log2(LINE_BYTES) | Byte offset inside the line |
| chk_len | output | log2(LINE_BYTES)+1 | Chunk byte count |
| chk_store | output | 1 | 1 = store, 0 = load |
| chk_data | output | LINE_BYTES*8 | Store data at line byte positions |
| rsp_valid | input | 1 | Response to the outstanding chunk |
| rsp_data | input | LINE_BYTES*8 | Returned line (loads) |
| rd_valid | output | 1 | Load bytes available |
| rd_pos | output | LEN_W | Transfer index of rd_bytes byte 0 |
| rd_len | output | log2(LINE_BYTES)+1 | Valid byte count in rd_bytes |
| rd_bytes | output | LINE_BYTES*8 | Load bytes shifted to byte 0 |
| done_valid | output | 1 | Transfer completion pulse |
| done_id | output | ID_W | ID of the completed transfer |

## Verification
The assertions assume that `rsp_valid` is raised only while a chunk has been accepted and is awaiting its answer, that exactly one response comes back per chunk, and that `wr_bytes` tracks `wr_base` within the same cycle. They also assume `req_len` never exceeds what `LEN_W` can count. The stimulus keeps to these rules. It sends one single-cycle response only after the chunk handshake, and it derives `wr_bytes` combinationally from `wr_base` with a fixed byte formula. Requests are offered only when the bench expects the block to be idle, except for the deliberate checks that `req_ready` is low while busy.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic [2:0] {
        KIND_NULL   = 3'd0,
        KIND_LOAD   = 3'd1,
        KIND_STORE  = 3'd2,
        KIND_IFETCH = 3'd3,
        KIND_LK_RD  = 3'd4,
        KIND_LK_WR  = 3'd5,
        KIND_RMW_RD = 3'd6,
        KIND_RMW_WR = 3'd7
    } req_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/dma_chunk_calc.sv
module dma_chunk_calc #(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 16,
    parameter int LINE_BYTES = 64,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int CL_W      = OFF_W + 1
) (
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LEN_W-1:0]  completed,
    input  logic [LEN_W-1:0]  total,
    output logic [ADDR_W-1:0] line_addr,
    output logic [OFF_W-1:0]  offset,
    output logic [CL_W-1:0]   len
);
    logic [ADDR_W-1:0] cur_addr;
    logic [CL_W-1:0]   room;
    logic [LEN_W-1:0]  remaining;

    always_comb begin
        cur_addr  = start_addr + ADDR_W'(completed);
        offset    = cur_addr[OFF_W-1:0];
        line_addr = {cur_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        room      = CL_W'(LINE_BYTES) - {1'b0, offset};
        remaining = total - completed;
        len       = (remaining < LEN_W'(room)) ? CL_W'(remaining) : room;
    end
endmodule

// File: rtl/dma_byte_shift.sv
module dma_byte_shift #(
    parameter int BYTES    = 64,
    parameter bit TO_UPPER = 1'b1,
    localparam int AMT_W   = $clog2(BYTES),
    localparam int DATA_W  = BYTES * 8
) (
    input  logic [DATA_W-1:0] din,
    input  logic [AMT_W-1:0]  amt,
    output logic [DATA_W-1:0] dout
);
    logic [AMT_W+2:0] bit_amt;
    assign bit_amt = {amt, 3'b000};

    generate
        if (TO_UPPER) begin : g_up
            assign dout = din << bit_amt;
        end else begin : g_down
            assign dout = din >> bit_amt;
        end
    endgenerate
endmodule

// File: rtl/dma_line_seq.sv
module dma_line_seq
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 16,
    parameter int LINE_BYTES = 64,
    parameter int ID_W       = 8,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int CL_W      = OFF_W + 1,
    localparam int DATA_W    = LINE_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [2:0]        req_kind,
    output logic [ID_W-1:0]   req_id,
    output logic              req_err,
    output logic              busy,
    output logic [LEN_W-1:0]  wr_base,
    input  logic [DATA_W-1:0] wr_bytes,
    output logic              chk_valid,
    input  logic              chk_ready,
    output logic [ADDR_W-1:0] chk_line_addr,
    output logic [OFF_W-1:0]  chk_offset,
    output logic [CL_W-1:0]   chk_len,
    output logic              chk_store,
    output logic [DATA_W-1:0] chk_data,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              rd_valid,
    output logic [LEN_W-1:0]  rd_pos,
    output logic [CL_W-1:0]   rd_len,
    output logic [DATA_W-1:0] rd_bytes,
    output logic              done_valid,
    output logic [ID_W-1:0]   done_id
);
    typedef struct packed {
        seq_state_e        st;
        logic [ADDR_W-1:0] start;
        logic [LEN_W-1:0]  total;
        logic [LEN_W-1:0]  issued;
        logic [LEN_W-1:0]  completed;
        logic              store;
        logic [ID_W-1:0]   id_ctr;
        logic [ID_W-1:0]   cur_id;
        logic              rd_v;
        logic [LEN_W-1:0]  rd_pos;
        logic [CL_W-1:0]   rd_len;
        logic [DATA_W-1:0] rd_bytes;
        logic              done_v;
        logic [ID_W-1:0]   done_id;
        logic              err;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic [ADDR_W-1:0] c_line;
    logic [OFF_W-1:0]  c_off;
    logic [CL_W-1:0]   c_len;
    logic [DATA_W-1:0] wr_placed;
    logic [DATA_W-1:0] rd_aligned;
    logic              kind_legal;
    logic              accept;

    dma_chunk_calc #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .LINE_BYTES(LINE_BYTES)
    ) u_calc (
        .start_addr(r_q.start),
        .completed (r_q.completed),
        .total     (r_q.total),
        .line_addr (c_line),
        .offset    (c_off),
        .len       (c_len)
    );

    dma_byte_shift #(.BYTES(LINE_BYTES), .TO_UPPER(1'b1)) u_wr_shift (
        .din (wr_bytes),
        .amt (c_off),
        .dout(wr_placed)
    );

    dma_byte_shift #(.BYTES(LINE_BYTES), .TO_UPPER(1'b0)) u_rd_shift (
        .din (rsp_data),
        .amt (c_off),
        .dout(rd_aligned)
    );

    assign kind_legal = (req_kind == KIND_LOAD) || (req_kind == KIND_STORE);
    assign req_ready  = (r_q.st == ST_IDLE);
    assign accept     = req_valid && req_ready;

    always_comb begin
        r_d        = r_q;
        r_d.rd_v   = 1'b0;
        r_d.done_v = 1'b0;
        r_d.err    = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (kind_legal) begin
                        r_d.id_ctr    = r_q.id_ctr + ID_W'(1);
                        r_d.cur_id    = r_q.id_ctr;
                        r_d.start     = req_addr;
                        r_d.total     = req_len;
                        r_d.issued    = '0;
                        r_d.completed = '0;
                        r_d.store     = (req_kind == KIND_STORE);
                        if (req_len == '0) begin
                            r_d.done_v  = 1'b1;
                            r_d.done_id = r_q.id_ctr;
                        end else begin
                            r_d.st = ST_ISSUE;
                        end
                    end else begin
                        r_d.err = 1'b1;
                    end
                end
            end
            ST_ISSUE: begin
                if (chk_ready) begin
                    r_d.issued = r_q.issued + LEN_W'(c_len);
                    r_d.st     = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (rsp_valid) begin
                    r_d.completed = r_q.issued;
                    if (!r_q.store) begin
                        r_d.rd_v     = 1'b1;
                        r_d.rd_pos   = r_q.completed;
                        r_d.rd_len   = CL_W'(r_q.issued - r_q.completed);
                        r_d.rd_bytes = rd_aligned;
                    end
                    if (r_q.issued == r_q.total) begin
                        r_d.done_v  = 1'b1;
                        r_d.done_id = r_q.cur_id;
                        r_d.st      = ST_IDLE;
                    end else begin
                        r_d.st = ST_ISSUE;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_id        = r_q.id_ctr;
    assign req_err       = r_q.err;
    assign busy          = (r_q.st != ST_IDLE);
    assign wr_base       = r_q.completed;
    assign chk_valid     = (r_q.st == ST_ISSUE);
    assign chk_line_addr = c_line;
    assign chk_offset    = c_off;
    assign chk_len       = c_len;
    assign chk_store     = r_q.store;
    assign chk_data      = r_q.store ? wr_placed : '0;
    assign rd_valid      = r_q.rd_v;
    assign rd_pos        = r_q.rd_pos;
    assign rd_len        = r_q.rd_len;
    assign rd_bytes      = r_q.rd_bytes;
    assign done_valid    = r_q.done_v;
    assign done_id       = r_q.done_id;

    AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !req_ready); // R1
    AST_ERR_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !kind_legal) |=> (req_err && !busy)); // R2
    AST_CHUNK_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |-> ((CL_W+1)'(chk_offset) + (CL_W+1)'(chk_len) <= (CL_W+1)'(LINE_BYTES))); // R3
    AST_CHUNK_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |-> (chk_len != '0)); // R5
    AST_LATER_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && wr_base != '0) |-> (chk_offset == '0)); // R4
    AST_CHUNK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && !chk_ready) |=> (chk_valid && $stable(chk_line_addr) && $stable(chk_len))); // R6
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && chk_ready) |=> !chk_valid); // R6
    AST_ISSUED_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (r_q.issued <= r_q.total)); // R5
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> (!busy && !chk_valid)); // R7
    AST_ID_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && kind_legal) |=> (req_id == $past(req_id) + ID_W'(1))); // R10
    AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && kind_legal && req_len == '0) |=> (done_valid && !busy)); // R11
endmodule

// File: tb/dma_line_seq_tb.sv
module dma_line_seq_tb;
    localparam int ADDR_W = 16;
    localparam int LEN_W  = 8;
    localparam int LB     = 8;
    localparam int ID_W   = 8;
    localparam int OFF_W  = 3;
    localparam int CL_W   = 4;
    localparam int DW     = LB * 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [LEN_W-1:0]  req_len = '0;
    logic [2:0]        req_kind = '0;
    logic [ID_W-1:0]   req_id;
    logic              req_err;
    logic              busy;
    logic [LEN_W-1:0]  wr_base;
    logic [DW-1:0]     wr_bytes;
    logic              chk_valid;
    logic              chk_ready = 1'b0;
    logic [ADDR_W-1:0] chk_line_addr;
    logic [OFF_W-1:0]  chk_offset;
    logic [CL_W-1:0]   chk_len;
    logic              chk_store;
    logic [DW-1:0]     chk_data;
    logic              rsp_valid = 1'b0;
    logic [DW-1:0]     rsp_data = '0;
    logic              rd_valid;
    logic [LEN_W-1:0]  rd_pos;
    logic [CL_W-1:0]   rd_len;
    logic [DW-1:0]     rd_bytes;
    logic              done_valid;
    logic [ID_W-1:0]   done_id;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    int exp_id   = 0;

    always #5 clk = ~clk;

    dma_line_seq #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .LINE_BYTES(LB), .ID_W(ID_W)
    ) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_len(req_len), .req_kind(req_kind), .req_id(req_id), .req_err(req_err),
        .busy(busy), .wr_base(wr_base), .wr_bytes(wr_bytes),
        .chk_valid(chk_valid), .chk_ready(chk_ready), .chk_line_addr(chk_line_addr),
        .chk_offset(chk_offset), .chk_len(chk_len), .chk_store(chk_store),
        .chk_data(chk_data), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rd_valid(rd_valid), .rd_pos(rd_pos), .rd_len(rd_len), .rd_bytes(rd_bytes),
        .done_valid(done_valid), .done_id(done_id)
    );

    function automatic logic [7:0] src_byte(int k);
        return 8'((k * 5) + 17);
    endfunction

    function automatic logic [7:0] mem_byte(int a);
        return 8'((a * 3) + 1);
    endfunction

    always_comb begin
        for (int i = 0; i < LB; i++) wr_bytes[i*8 +: 8] = src_byte(int'(wr_base) + i);
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            summary();
        end
    end

    task automatic run(input int start, input int len, input bit store);
        int done;
        int cur;
        int off;
        int clen;
        int line;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = ADDR_W'(start);
        req_len   = LEN_W'(len);
        req_kind  = store ? 3'd2 : 3'd1;
        check(req_ready == 1'b1, "R1 ready when idle", req_ready, 1);
        check(int'(req_id) == exp_id, "R10 id offered", req_id, exp_id);
        @(negedge clk);
        req_valid = 1'b0;
        if (len == 0) begin
            check(done_valid && int'(done_id) == exp_id, "R11 zero length done", done_id, exp_id);
            check(!busy && !chk_valid, "R11 no chunk", chk_valid, 0);
            exp_id = (exp_id + 1) % 256;
            return;
        end
        check(busy && !req_ready, "R1 busy blocks requests", req_ready, 0);
        done = 0;
        while (done < len) begin
            cur  = start + done;
            off  = cur % LB;
            clen = (len - done < LB - off) ? len - done : LB - off;
            line = cur - off;
            check(chk_valid == 1'b1, "R6 chunk offered", chk_valid, 1);
            check(int'(chk_line_addr) == line, done == 0 ? "R3 line addr" : "R4 line addr", chk_line_addr, line);
            check(int'(chk_offset) == off, done == 0 ? "R3 offset" : "R4 offset zero", chk_offset, off);
            check(int'(chk_len) == clen, done == 0 ? "R3 first length" : "R5 later length", chk_len, clen);
            check(chk_store == store, "R9 store flag", chk_store, store);
            if (store) begin
                check(int'(wr_base) == done, "R9 write base", wr_base, done);
                for (int i = 0; i < clen; i++)
                    check(chk_data[(off+i)*8 +: 8] == src_byte(done + i), "R9 store byte",
                          chk_data[(off+i)*8 +: 8], src_byte(done + i));
            end else begin
                check(chk_data == '0, "R9 load data zero", chk_data, 0);
            end
            if (((start + len + done) % 3) == 0) begin
                @(negedge clk);
                check(chk_valid && int'(chk_len) == clen && int'(chk_line_addr) == line,
                      "R6 hold while stalled", chk_len, clen);
            end
            chk_ready = 1'b1;
            @(negedge clk);
            chk_ready = 1'b0;
            check(chk_valid == 1'b0, "R6 none while waiting", chk_valid, 0);
            @(negedge clk);
            check(chk_valid == 1'b0, "R6 still waiting", chk_valid, 0);
            rsp_valid = 1'b1;
            for (int i = 0; i < LB; i++) rsp_data[i*8 +: 8] = mem_byte(line + i);
            @(negedge clk);
            rsp_valid = 1'b0;
            if (!store) begin
                check(rd_valid == 1'b1, "R8 read pulse", rd_valid, 1);
                check(int'(rd_pos) == done, "R8 read position", rd_pos, done);
                check(int'(rd_len) == clen, "R8 read length", rd_len, clen);
                for (int j = 0; j < clen; j++)
                    check(rd_bytes[j*8 +: 8] == mem_byte(cur + j), "R8 read byte",
                          rd_bytes[j*8 +: 8], mem_byte(cur + j));
            end else begin
                check(rd_valid == 1'b0, "R8 no read on store", rd_valid, 0);
            end
            done += clen;
            if (done == len) begin
                check(done_valid && int'(done_id) == exp_id, "R7 completion id", done_id, exp_id);
                check(!busy, "R1 busy clears", busy, 0);
            end else begin
                check(!done_valid && busy, "R7 no early completion", done_valid, 0);
            end
        end
        @(negedge clk);
        check(!done_valid, "R7 single pulse", done_valid, 0);
        exp_id = (exp_id + 1) % 256;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(!busy && req_ready && !chk_valid && !rd_valid && !done_valid && !req_err,
              "R12 reset outputs", busy, 0);
        check(req_id == '0, "R12 id after reset", req_id, 0);

        for (int k = 0; k < 8; k++) begin
            if (k == 1 || k == 2) continue;
            @(negedge clk);
            req_valid = 1'b1;
            req_kind  = 3'(k);
            req_len   = 8'd5;
            req_addr  = 16'h0013;
            @(negedge clk);
            req_valid = 1'b0;
            check(req_err == 1'b1, "R2 illegal kind flagged", req_err, 1);
            check(!busy && !chk_valid, "R2 no transfer started", busy, 0);
            check(int'(req_id) == exp_id, "R2 no id consumed", req_id, exp_id);
            @(negedge clk);
            check(req_err == 1'b0, "R2 error is a pulse", req_err, 0);
        end

        for (int dir = 0; dir < 2; dir++)
            for (int off = 0; off < LB; off++)
                for (int len = 0; len <= 20; len++)
                    run(16'h0040 + (len * 24) + off, len, dir[0]);

        summary();
    end
endmodule